// File: doc/BRIEF.md
# Shifter With Carry-Out

This block shifts or rotates a 32-bit value by a distance taken from a 32-bit register operand and produces both the shifted value and the updated carry flag. A 2-bit opcode picks one of four operations: logical shift left, logical shift right, arithmetic shift right or rotate right. Only the low byte of the register operand sets the distance, so distances run from 0 to 255. Distances of 32 and above each give a defined result and a defined carry, following the flag rules of a general-purpose processor's data path.

The datapath is combinational: a five-stage logarithmic shifter for the value and a separate multiplexer that picks the carry bit. A parameter adds an output register, which is the default. With the register in place, the result and carry appear one clock after the inputs. Immediate-form shifts and the rotate-through-carry-by-one case are handled elsewhere in the pipeline.

Top module: `shf_unit`

## Requirements
- R1: The distance n is bits 7:0 of `amt_reg_i`. Bits 31:8 have no effect on the result or the carry.
- R2: When n = 0, for every opcode, the result equals the input value and the carry-out equals `carry_i`.
- R3: Opcode 2'b00 is logical shift left. For n in 1..31 the result is the value shifted left with zeros filled in, and the carry is input bit (32 - n). For n = 32 the result is 0 and the carry is input bit 0. For n > 32 both the result and the carry are 0.
- R4: Opcode 2'b01 is logical shift right. For n in 1..31 the result is the value shifted right with zeros filled in, and the carry is input bit (n - 1). For n = 32 the result is 0 and the carry is input bit 31. For n > 32 both the result and the carry are 0.
- R5: Opcode 2'b10 is arithmetic shift right. For n in 1..31 the vacated bits take input bit 31, and the carry is input bit (n - 1). For n >= 32 every result bit and the carry equal input bit 31.
- R6: Opcode 2'b11 is rotate right by r = n mod 32. If r = 0 while n != 0, the result is unchanged and the carry is input bit 31. Otherwise the result is the value rotated right by r, and the carry is input bit (r - 1).
- R7: With the output register enabled (the default), the result and the carry change only on a rising clock edge. They reflect the inputs that were present at that edge.
- R8: While `rst_n` is low, `result_o` and `carry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Value to shift or rotate |
| amt_reg_i | input | 32 | Register operand; bits 7:0 give the distance |
| op_i | input | 2 | Operation select: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted or rotated value |
| carry_o | output | 1 | Updated carry flag |

## Verification
A wrong stage select in the logarithmic shifter shows up at the port as a result displaced by a power-of-two distance, one clock after the inputs. It appears only for distances whose binary form uses that stage, so every distance from 0 to 255 is swept for each opcode. A wrong carry index or a wrong range test shows up as a flipped `carry_o` in the same cycle as the result, and is most likely at the edges 1, 31, 32, 33 and multiples of 32. Random operands with the high bits of the register operand set expose any leak of those bits into the distance.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Operation select; the encoding is visible at the top-level port
    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SHR = 2'b01,
        OP_SAR = 2'b10,
        OP_ROT = 2'b11
    } shf_op_e;

endpackage

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter int W     = 32,
    parameter int LOG2W = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  logic [LOG2W-1:0] dist_i,
    input  shf_op_e          op_i,
    input  logic             over_i,
    output logic [W-1:0]     data_o
);

    logic               left;
    logic               rot;
    logic               fill;
    logic [W-1:0]       in_rev;
    logic [W-1:0]       out_rev;
    logic [LOG2W:0][W-1:0] stage;

    assign left = (op_i == OP_SHL);
    assign rot  = (op_i == OP_ROT);
    assign fill = (op_i == OP_SAR) & data_i[W-1];

    // A left shift is done as a right shift of the bit-reversed value
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign in_rev[i]  = data_i[W-1-i];
        assign out_rev[i] = stage[LOG2W][W-1-i];
    end

    assign stage[0] = left ? in_rev : data_i;

    for (genvar k = 0; k < LOG2W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = !dist_i[k] ? stage[k] :
                            rot        ? {stage[k][STEP-1:0], stage[k][W-1:STEP]} :
                                         {{STEP{fill}}, stage[k][W-1:STEP]};
    end

    always_comb begin
        data_o = left ? out_rev : stage[LOG2W];
        if (over_i && !rot) begin
            data_o = (op_i == OP_SAR) ? {W{data_i[W-1]}} : '0;
        end
    end

endmodule

// File: rtl/shf_carry.sv
module shf_carry
    import shf_pkg::*;
#(
    parameter int W     = 32,
    parameter int AMT_W = 8,
    parameter int LOG2W = $clog2(W)
) (
    input  logic [W-1:0]     data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  shf_op_e          op_i,
    input  logic             carry_i,
    output logic             carry_o
);

    logic [AMT_W-1:0] amt_m1;
    logic [AMT_W-1:0] amt_neg;
    logic [LOG2W-1:0] idx_r;
    logic [LOG2W-1:0] idx_l;
    logic             in_range;
    logic             is_zero;

    assign amt_m1   = amt_i - AMT_W'(1);
    assign amt_neg  = AMT_W'(W) - amt_i;
    assign idx_r    = amt_m1[LOG2W-1:0];   // n-1, and (r-1) mod W for rotate
    assign idx_l    = amt_neg[LOG2W-1:0];  // W-n
    assign in_range = (amt_i <= AMT_W'(W));
    assign is_zero  = (amt_i == '0);

    always_comb begin
        carry_o = carry_i;
        if (!is_zero) begin
            unique case (op_i)
                OP_SHL:  carry_o = in_range ? data_i[idx_l] : 1'b0;
                OP_SHR:  carry_o = in_range ? data_i[idx_r] : 1'b0;
                OP_SAR:  carry_o = in_range ? data_i[idx_r] : data_i[W-1];
                OP_ROT:  carry_o = data_i[idx_r];
                default: carry_o = carry_i;
            endcase
        end
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int W       = 32,
    parameter int AMT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] amt_reg_i,
    input  logic [1:0]   op_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);

    localparam int LOG2W = $clog2(W);

    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
    } shf_out_t;

    shf_op_e          op;
    logic [AMT_W-1:0] amt;
    logic             over;
    logic [W-1:0]     shifted;
    logic             cout;
    logic             unused_hi;
    shf_out_t         out_d;
    shf_out_t         out_q;

    assign op        = shf_op_e'(op_i);
    assign amt       = amt_reg_i[AMT_W-1:0];
    assign over      = |amt[AMT_W-1:LOG2W];
    assign unused_hi = ^amt_reg_i[W-1:AMT_W];

    shf_barrel #(.W(W), .LOG2W(LOG2W)) u_barrel (
        .data_i (src_i),
        .dist_i (amt[LOG2W-1:0]),
        .op_i   (op),
        .over_i (over),
        .data_o (shifted)
    );

    shf_carry #(.W(W), .AMT_W(AMT_W), .LOG2W(LOG2W)) u_carry (
        .data_i  (src_i),
        .amt_i   (amt),
        .op_i    (op),
        .carry_i (carry_i),
        .carry_o (cout)
    );

    always_comb begin
        out_d.value = shifted;
        out_d.carry = cout;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end

        p_amt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (amt == '0) |=> (result_o == $past(src_i) && carry_o == $past(carry_i)));

        p_shl_far_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_SHL && amt > AMT_W'(W)) |=> (result_o == '0 && !carry_o));

        p_shr_far_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_SHR && amt > AMT_W'(W)) |=> (result_o == '0 && !carry_o));

        p_sar_far_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_SAR && amt >= AMT_W'(W)) |=>
            (result_o == {W{$past(src_i[W-1])}} && carry_o == $past(src_i[W-1])));

        p_rot_whole_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_ROT && amt != '0 && amt[LOG2W-1:0] == '0) |=>
            (result_o == $past(src_i) && carry_o == $past(src_i[W-1])));
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign out_q      = out_d;
    end

    assign result_o = out_q.value;
    assign carry_o  = out_q.carry;

endmodule

// File: tb/shf_unit_tb.sv
module shf_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [31:0] amt_reg = '0;
    logic [1:0]  op = '0;
    logic        cin = 1'b0;
    logic [31:0] result;
    logic        cout;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    shf_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src),
        .amt_reg_i (amt_reg),
        .op_i      (op),
        .carry_i   (cin),
        .result_o  (result),
        .carry_o   (cout)
    );

    function automatic logic [32:0] model(input logic [31:0] x, input logic [7:0] n,
                                          input logic [1:0] o, input logic c);
        logic [31:0] r;
        logic        k;
        int          m;
        m = int'(n);
        r = x;
        k = c;
        if (m != 0) begin
            case (o)
                2'b00: begin
                    if (m < 32)       begin r = x << m; k = x[32-m]; end
                    else if (m == 32) begin r = '0; k = x[0]; end
                    else              begin r = '0; k = 1'b0; end
                end
                2'b01: begin
                    if (m < 32)       begin r = x >> m; k = x[m-1]; end
                    else if (m == 32) begin r = '0; k = x[31]; end
                    else              begin r = '0; k = 1'b0; end
                end
                2'b10: begin
                    if (m < 32) begin r = 32'($signed(x) >>> m); k = x[m-1]; end
                    else        begin r = {32{x[31]}}; k = x[31]; end
                end
                default: begin
                    int q;
                    q = m % 32;
                    if (q == 0) begin r = x; k = x[31]; end
                    else begin r = (x >> q) | (x << (32 - q)); k = x[q-1]; end
                end
            endcase
        end
        return {k, r};
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [7:0] n);
        if (n == 0) return "R2";
        case (o)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] er, input logic ec);
        n_chk++;
        if (result !== er || cout !== ec) begin
            n_bad++;
            $display("FAIL %s: got result=%h carry=%b expected result=%h carry=%b",
                     tag, result, cout, er, ec);
        end
    endtask

    task automatic run(input logic [31:0] x, input logic [31:0] a,
                       input logic [1:0] o, input logic c, input string tag);
        logic [32:0] e;
        @(negedge clk);
        src = x; amt_reg = a; op = o; cin = c;
        e = model(x, a[7:0], o, c);
        @(posedge clk);
        #1;
        compare(tag, e[31:0], e[32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [32:0] e;
        void'($urandom(32'h5EED_1234));
        src = 32'hDEAD_BEEF; amt_reg = 32'd3; op = 2'b01; cin = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        compare("R8", 32'h0, 1'b0);           // R8: reset holds outputs at zero
        @(negedge clk);
        rst_n = 1'b1;

        // Full sweep of every distance for each opcode with two patterns
        for (int o = 0; o < 4; o++) begin
            for (int n = 0; n < 256; n++) begin
                run(32'h8000_0001 ^ (32'h1 << (n % 32)), 32'(n), 2'(o), n[0],
                    tag_of(2'(o), 8'(n)));
                run(32'h7F3C_A5E1, 32'(n), 2'(o), ~n[0], tag_of(2'(o), 8'(n)));
            end
        end

        // Directed edges
        run(32'h0000_0001, 32'd32, 2'b00, 1'b0, "R3");  // carry from bit 0
        run(32'h8000_0000, 32'd32, 2'b01, 1'b0, "R4");  // carry from bit 31
        run(32'hFFFF_FFFF, 32'd33, 2'b01, 1'b1, "R4");  // result 0 carry 0
        run(32'h8000_0000, 32'd200, 2'b10, 1'b0, "R5"); // sign fill
        run(32'h8000_1234, 32'd64, 2'b11, 1'b0, "R6");  // whole turns
        run(32'h1234_5678, 32'd0, 2'b11, 1'b1, "R2");

        // R1: high bits of the register operand must not matter
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] x;
            a = $urandom();
            x = $urandom();
            if (i % 8 == 0) a[7:0] = 8'(32 * ($urandom() % 8));
            run(x, a, 2'($urandom()), 1'($urandom()), "R1");
        end

        // R7: output holds between edges while inputs change
        run(32'hCAFE_0001, 32'd4, 2'b00, 1'b0, "R7");
        e = model(32'hCAFE_0001, 8'd4, 2'b00, 1'b0);
        @(negedge clk);
        src = 32'h0; amt_reg = 32'd1; op = 2'b11; cin = 1'b1;
        #2;
        compare("R7", e[31:0], e[32]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule